// File: doc/BRIEF.md
# Scatter-Gather Descriptor List Walker

This block serves one DMA channel. It reads a list of fixed 8-byte descriptors from consecutive memory slots and turns each one into a single burst command made of a buffer address and a byte count. The data mover that carries out the command is a separate block. Descriptors are fetched through a request/response memory read port that allows one read in flight. Commands leave on a valid/ready port, and a single-cycle done pulse marks the end of a list.

Software programs the channel through a small register write port. The `IS_RX` parameter selects how a walk starts and stops. A transmit channel starts when the low list-address register is written. A receive channel starts on a rising edge of its enable bit, and clearing that bit stops the walk. Only a receive channel has a bytes-per-row value, which travels with every command. A descriptor that fails its checks ends the walk and sets a sticky error flag.

Top module: `sgf_top`

## Requirements
- R1: After reset, `cmd_valid`, `mem_req`, `done` and `err` are all low.
- R2: Descriptor layout is little-endian. Bits [63:32] are the buffer address and go to `cmd_addr`. Bits [31:16] are the byte count and go to `cmd_len`. Bits [15:8] are reserved. In bits [7:0], bit 0 is valid, bit 1 is last and bit 5 is transfer.
- R3: Descriptors are read from the programmed list address upward in steps of 8 bytes. The list address is written at register offset 0x04, and its bits [2:0] are treated as zero. A write to offset 0x00 (high address) has no effect on any fetch.
- R4: Transmit variant: a write to offset 0x04 starts a walk only while the channel is idle. The same write during a walk is ignored and leaves the walk unchanged.
- R5: Receive variant: a walk starts when a write to offset 0x14 moves bit 0 from 0 to 1. Writing 1 while the bit is already set starts nothing. The value written at offset 0x30 appears on `cmd_row` with every command.
- R6: Receive variant: writing 0 to bit 0 at offset 0x14 ends the walk at that clock edge. After that edge `cmd_valid` and `mem_req` are low, and no done pulse follows.
- R7: A descriptor that has the valid bit clear, or whose byte count is not a multiple of 4, produces no command. It ends the walk without a done pulse and sets `err`. `err` stays set until the next walk starts.
- R8: A valid descriptor with the transfer bit clear is skipped without a command, and the walk continues. If that descriptor is marked last, the walk ends with a done pulse.
- R9: `done` is high for exactly one cycle per list. That cycle immediately follows the acceptance of the command for the last descriptor.
- R10: While `cmd_valid` is high and `cmd_ready` is low, the command stays valid and its fields do not change.
- R11: If a receive stop falls in the same cycle as the acceptance of the last command, the command counts as accepted, but no done pulse is produced.
- R12: `mem_addr` is always 8-byte aligned, and the block never asserts `mem_req` and `cmd_valid` together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Descriptor read request, held until the response |
| mem_addr | output | 32 | Descriptor slot address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 64 | Descriptor contents |
| cmd_valid | output | 1 | Burst command valid |
| cmd_ready | input | 1 | Burst command accepted by the data mover |
| cmd_addr | output | 32 | Buffer address of the command |
| cmd_len | output | 16 | Byte count of the command |
| cmd_row | output | ROW_W | Bytes per row (receive), zero for transmit |
| done | output | 1 | One-cycle end-of-list pulse |
| err | output | 1 | Sticky bad-descriptor flag |

## Verification
The interesting collision is a receive stop that arrives in the same clock edge where the data mover accepts the command for the final descriptor. The bench holds `cmd_ready` low until that command is waiting. It then raises `cmd_ready` and writes 0 to the enable bit in the same cycle. The result is judged at the ports: exactly one command must be counted as accepted, no done pulse may appear, and the command port must be idle afterwards.

// File: rtl/sgf_pkg.sv
package sgf_pkg;
  localparam int unsigned SLOT_BYTES = 8;
  localparam int unsigned FLAG_VALID = 0;
  localparam int unsigned FLAG_LAST  = 1;
  localparam int unsigned FLAG_XFER  = 5;

  localparam logic [7:0] OFS_HI  = 8'h00;
  localparam logic [7:0] OFS_LO  = 8'h04;
  localparam logic [7:0] OFS_EN  = 8'h14;
  localparam logic [7:0] OFS_ROW = 8'h30;

  typedef enum logic [1:0] {
    WK_IDLE  = 2'd0,
    WK_FETCH = 2'd1,
    WK_ISSUE = 2'd2
  } walk_st_e;

  typedef struct packed {
    logic [31:0] addr;
    logic [15:0] len;
    logic        last;
    logic        xfer;
  } desc_t;
endpackage

// File: rtl/sgf_regs.sv
module sgf_regs #(
  parameter bit IS_RX = 1'b0,
  parameter int unsigned REG_AW = 8,
  parameter int unsigned ROW_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              idle,
  output logic [31:0]       start_addr,
  output logic [ROW_W-1:0]  row,
  output logic              start,
  output logic              stop
);
  import sgf_pkg::*;

  logic        hit_lo;
  logic        base_ce;
  logic [31:0] base_q;
  logic [31:0] base_d;

  // the high-address offset is decoded by nobody: writes there are dropped
  assign hit_lo  = wr_en && (wr_addr == REG_AW'(OFS_LO));
  assign base_ce = hit_lo && idle;
  assign base_d  = {wr_data[31:3], 3'b000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_ce) base_q <= base_d;
  end

  generate
    if (IS_RX) begin : g_rx
      logic             en_q, en_d, en_ce;
      logic             row_ce;
      logic [ROW_W-1:0] row_q;

      assign en_ce  = wr_en && (wr_addr == REG_AW'(OFS_EN));
      assign en_d   = wr_data[0];
      assign row_ce = wr_en && (wr_addr == REG_AW'(OFS_ROW));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          en_q  <= 1'b0;
          row_q <= '0;
        end else begin
          if (en_ce)  en_q  <= en_d;
          if (row_ce) row_q <= wr_data[ROW_W-1:0];
        end
      end

      assign start      = en_ce && en_d && !en_q && idle;
      assign stop       = en_ce && !en_d;
      assign start_addr = base_q;
      assign row        = row_q;
    end else begin : g_tx
      assign start      = base_ce;
      assign stop       = 1'b0;
      assign start_addr = base_d;
      assign row        = '0;
    end
  endgenerate
endmodule

// File: rtl/sgf_decode.sv
module sgf_decode (
  input  logic [63:0]   raw,
  output sgf_pkg::desc_t desc,
  output logic          good
);
  import sgf_pkg::*;

  logic [7:0] flags;
  assign flags     = raw[7:0];
  assign desc.addr = raw[63:32];
  assign desc.len  = raw[31:16];
  assign desc.last = flags[FLAG_LAST];
  assign desc.xfer = flags[FLAG_XFER];
  assign good      = flags[FLAG_VALID] && (raw[17:16] == 2'b00);
endmodule

// File: rtl/sgf_walk.sv
module sgf_walk (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [31:0]    start_addr,
  input  logic           stop,
  input  logic           mem_rvalid,
  input  sgf_pkg::desc_t desc,
  input  logic           good,
  input  logic           cmd_ready,
  output logic           mem_req,
  output logic [31:0]    mem_addr,
  output logic           cmd_valid,
  output logic [31:0]    cmd_addr,
  output logic [15:0]    cmd_len,
  output logic           done,
  output logic           err,
  output logic           idle
);
  import sgf_pkg::*;

  walk_st_e    st_q, st_d;
  logic [31:0] ptr_q, ptr_d;
  desc_t       cur_q, cur_d;
  logic        done_q, done_d;
  logic        err_q, err_d;
  logic [31:0] ptr_inc;

  assign ptr_inc = ptr_q + 32'(SLOT_BYTES);

  always_comb begin
    st_d   = st_q;
    ptr_d  = ptr_q;
    cur_d  = cur_q;
    err_d  = err_q;
    done_d = 1'b0;
    unique case (st_q)
      WK_IDLE: begin
        if (start) begin
          st_d  = WK_FETCH;
          ptr_d = start_addr;
          err_d = 1'b0;
        end
      end
      WK_FETCH: begin
        if (stop) begin
          st_d = WK_IDLE;
        end else if (mem_rvalid) begin
          if (!good) begin
            err_d = 1'b1;
            st_d  = WK_IDLE;
          end else if (desc.xfer) begin
            cur_d = desc;
            st_d  = WK_ISSUE;
          end else if (desc.last) begin
            done_d = 1'b1;
            st_d   = WK_IDLE;
          end else begin
            ptr_d = ptr_inc;
          end
        end
      end
      WK_ISSUE: begin
        if (cmd_ready) begin
          if (cur_q.last) begin
            done_d = !stop;
            st_d   = WK_IDLE;
          end else begin
            ptr_d = ptr_inc;
            st_d  = WK_FETCH;
          end
        end
        if (stop) st_d = WK_IDLE;
      end
      default: st_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WK_IDLE;
      ptr_q  <= '0;
      cur_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      ptr_q  <= ptr_d;
      cur_q  <= cur_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign mem_req   = (st_q == WK_FETCH);
  assign mem_addr  = ptr_q;
  assign cmd_valid = (st_q == WK_ISSUE);
  assign cmd_addr  = cur_q.addr;
  assign cmd_len   = cur_q.len;
  assign done      = done_q;
  assign err       = err_q;
  assign idle      = (st_q == WK_IDLE);
endmodule

// File: rtl/sgf_top.sv
module sgf_top #(
  parameter bit IS_RX = 1'b0,
  parameter int unsigned REG_AW = 8,
  parameter int unsigned ROW_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              mem_req,
  output logic [31:0]       mem_addr,
  input  logic              mem_rvalid,
  input  logic [63:0]       mem_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [31:0]       cmd_addr,
  output logic [15:0]       cmd_len,
  output logic [ROW_W-1:0]  cmd_row,
  output logic              done,
  output logic              err
);
  import sgf_pkg::*;

  logic        rst_meta_q, rst_sync_q;
  logic        ctl_start, ctl_stop, wk_idle, dsc_good;
  logic [31:0] ctl_addr;
  desc_t       dsc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  sgf_regs #(.IS_RX(IS_RX), .REG_AW(REG_AW), .ROW_W(ROW_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_q), .wr_en(reg_wr), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .idle(wk_idle), .start_addr(ctl_addr),
    .row(cmd_row), .start(ctl_start), .stop(ctl_stop)
  );

  sgf_decode u_dec (.raw(mem_rdata), .desc(dsc), .good(dsc_good));

  sgf_walk u_walk (
    .clk(clk), .rst_n(rst_sync_q), .start(ctl_start), .start_addr(ctl_addr),
    .stop(ctl_stop), .mem_rvalid(mem_rvalid), .desc(dsc), .good(dsc_good),
    .cmd_ready(cmd_ready), .mem_req(mem_req), .mem_addr(mem_addr),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .done(done), .err(err), .idle(wk_idle)
  );
endmodule

// File: rtl/sgf_chk.sv
module sgf_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        stop,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [31:0] cmd_addr,
  input logic [15:0] cmd_len,
  input logic        done,
  input logic        err
);
  assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready && !stop |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_len));

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_valid && !mem_req);

  assert_stop_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !cmd_valid && !mem_req);

  assert_len_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_len[1:0] == 2'b00);

  assert_err_nocmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !cmd_valid && !done);

  assert_slot_align_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[2:0] == 3'b000);

  assert_one_side_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && cmd_valid));
endmodule

bind sgf_top sgf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stop(ctl_stop), .mem_req(mem_req),
  .mem_addr(mem_addr), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_addr(cmd_addr), .cmd_len(cmd_len), .done(done), .err(err)
);

// File: tb/sgf_top_test.sv
`timescale 1ns/1ps
module sgf_top_test;
  localparam int unsigned PERIOD = 20;

  typedef struct packed {
    logic [7:0]  slot;
    logic [3:0]  ncmd;
    logic [3:0]  ndone;
    logic        err;
    logic [31:0] first_addr;
    logic [15:0] first_len;
    logic [31:0] last_addr;
  } vec_t;

  localparam vec_t VECS [0:4] = '{
    '{8'd0,  4'd3, 4'd1, 1'b0, 32'h0000_1000, 16'd16,    32'h0000_1200},
    '{8'd8,  4'd1, 4'd1, 1'b0, 32'hDEAD_BEE0, 16'd65532, 32'hDEAD_BEE0},
    '{8'd12, 4'd1, 4'd0, 1'b1, 32'h0000_3000, 16'd8,     32'h0000_3000},
    '{8'd16, 4'd0, 4'd0, 1'b1, 32'h0000_0000, 16'd0,     32'h0000_0000},
    '{8'd20, 4'd1, 4'd1, 1'b0, 32'h0000_5000, 16'd32,    32'h0000_5000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic [63:0] mem [0:63];

  logic        t_wr = 0, r_wr = 0, t_rdy = 0, r_rdy = 0;
  logic [7:0]  t_wa = 0, r_wa = 0;
  logic [31:0] t_wd = 0, r_wd = 0;
  logic        t_mreq, r_mreq, t_rv, r_rv, t_cv, r_cv, t_done, r_done, t_err, r_err;
  logic [31:0] t_maddr, r_maddr, t_caddr, r_caddr;
  logic [63:0] t_rd, r_rd;
  logic [15:0] t_clen, r_clen, t_row, r_row;

  sgf_top #(.IS_RX(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(t_wr), .reg_addr(t_wa), .reg_wdata(t_wd),
    .mem_req(t_mreq), .mem_addr(t_maddr), .mem_rvalid(t_rv), .mem_rdata(t_rd),
    .cmd_valid(t_cv), .cmd_ready(t_rdy), .cmd_addr(t_caddr), .cmd_len(t_clen),
    .cmd_row(t_row), .done(t_done), .err(t_err));

  sgf_top #(.IS_RX(1'b1)) uut_rx (
    .clk(clk), .rst_n(rst_n), .reg_wr(r_wr), .reg_addr(r_wa), .reg_wdata(r_wd),
    .mem_req(r_mreq), .mem_addr(r_maddr), .mem_rvalid(r_rv), .mem_rdata(r_rd),
    .cmd_valid(r_cv), .cmd_ready(r_rdy), .cmd_addr(r_caddr), .cmd_len(r_clen),
    .cmd_row(r_row), .done(r_done), .err(r_err));

  // memory models: one read in flight, answer one cycle after the request
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_rv <= 1'b0; r_rv <= 1'b0; t_rd <= '0; r_rd <= '0;
    end else begin
      t_rv <= t_mreq && !t_rv;  t_rd <= mem[t_maddr[8:3]];
      r_rv <= r_mreq && !r_rv;  r_rd <= mem[r_maddr[8:3]];
    end
  end

  int cyc = 0;
  int t_ncmd, t_ndone, r_ncmd, r_ndone, t_acc_cyc, t_done_cyc;
  logic [31:0] t_first_a, t_last_a, r_first_a;
  logic [15:0] t_first_l, r_row_seen;
  int checks = 0, errors = 0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (t_cv && t_rdy) begin
      if (t_ncmd == 0) begin t_first_a = t_caddr; t_first_l = t_clen; end
      t_last_a = t_caddr; t_ncmd++; t_acc_cyc = cyc;
    end
    if (t_done) begin t_ndone++; t_done_cyc = cyc; end
    if (r_cv && r_rdy) begin
      if (r_ncmd == 0) r_first_a = r_caddr;
      r_row_seen = r_row; r_ncmd++;
    end
    if (r_done) r_ndone++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wr_t(input logic [7:0] a, input logic [31:0] d);
    t_wr = 1; t_wa = a; t_wd = d; tick(1); t_wr = 0;
  endtask

  task automatic wr_r(input logic [7:0] a, input logic [31:0] d);
    r_wr = 1; r_wa = a; r_wd = d; tick(1); r_wr = 0;
  endtask

  task automatic clr_counts();
    t_ncmd = 0; t_ndone = 0; r_ncmd = 0; r_ndone = 0;
    t_first_a = 0; t_first_l = 0; t_last_a = 0; t_acc_cyc = -5; t_done_cyc = -9;
  endtask

  function automatic logic [63:0] mk(input logic [31:0] a, input logic [15:0] l,
                                     input logic [7:0] f);
    return {a, l, 8'h00, f};
  endfunction

  initial begin
    #(PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    mem[0]  = mk(32'h1000, 16'd16, 8'h21);
    mem[1]  = mk(32'h1100, 16'd32, 8'h21);
    mem[2]  = mk(32'h1200, 16'd48, 8'h23);
    mem[8]  = mk(32'hDEADBEE0, 16'd65532, 8'h23);
    mem[12] = mk(32'h3000, 16'd8, 8'h21);
    mem[13] = mk(32'h3100, 16'd8, 8'h20);
    mem[16] = mk(32'h4000, 16'd6, 8'h23);
    mem[20] = mk(32'h5100, 16'd12, 8'h01);
    mem[21] = mk(32'h5000, 16'd32, 8'h23);
    clr_counts();
    tick(3);
    rst_n = 1;
    tick(3);
    // R1 reset state
    chk(!t_cv && !t_mreq && !t_done && !t_err, "R1", "tx idle after reset",
        {t_cv, t_mreq, t_done, t_err}, 0);
    chk(!r_cv && !r_mreq && !r_done && !r_err, "R1", "rx idle after reset",
        {r_cv, r_mreq, r_done, r_err}, 0);

    // vector table on the transmit channel, ready toggling on odd vectors
    for (int v = 0; v < 5; v++) begin
      clr_counts();
      wr_t(8'h00, 32'hFFFF_FFFF);          // R3: high address must not matter
      wr_t(8'h04, {21'd0, VECS[v].slot, 3'b101}); // R3: low bits dropped
      for (int c = 0; c < 60; c++) begin
        t_rdy = (v % 2 == 0) ? 1'b1 : c[0];
        tick(1);
      end
      t_rdy = 0;
      chk(t_ncmd == VECS[v].ncmd, "R2", "command count", t_ncmd, VECS[v].ncmd);
      chk(t_ndone == VECS[v].ndone, "R9", "done pulses", t_ndone, VECS[v].ndone);
      chk(t_err == VECS[v].err, "R7", "error flag", t_err, VECS[v].err);
      if (VECS[v].ncmd != 0) begin
        chk(t_first_a == VECS[v].first_addr, "R2", "first address", t_first_a, VECS[v].first_addr);
        chk(t_first_l == VECS[v].first_len, "R2", "first length", t_first_l, VECS[v].first_len);
        chk(t_last_a == VECS[v].last_addr, "R3", "last address", t_last_a, VECS[v].last_addr);
      end
      if (VECS[v].ndone != 0)
        chk(t_done_cyc == t_acc_cyc + 1, "R9", "done one cycle after accept",
            t_done_cyc, t_acc_cyc + 1);
      if (v == 4) chk(t_first_a != 32'h5100, "R8", "skipped descriptor", t_first_a, 32'h5000);
    end

    // R4 / R10: rewrite of the low register during a walk is ignored
    clr_counts();
    wr_t(8'h04, 32'h0);
    tick(10);
    chk(t_cv && t_caddr == 32'h1000, "R10", "held command", t_caddr, 32'h1000);
    wr_t(8'h04, 32'd64);
    tick(5);
    chk(t_cv && t_caddr == 32'h1000 && t_clen == 16'd16, "R10", "still held",
        t_caddr, 32'h1000);
    t_rdy = 1; tick(40); t_rdy = 0;
    chk(t_ncmd == 3 && t_last_a == 32'h1200, "R4", "busy write ignored", t_ncmd, 3);
    chk(t_ndone == 1, "R4", "one done", t_ndone, 1);

    // R5 receive start on enable rising edge, row value carried
    clr_counts();
    wr_r(8'h30, 32'h280);
    wr_r(8'h04, 32'h0);
    wr_r(8'h14, 32'h1);
    r_rdy = 1; tick(40);
    chk(r_ncmd == 3 && r_first_a == 32'h1000, "R5", "rx walk", r_ncmd, 3);
    chk(r_row_seen == 16'h280, "R5", "row value", r_row_seen, 32'h280);
    chk(r_ndone == 1, "R9", "rx done", r_ndone, 1);
    clr_counts();
    wr_r(8'h14, 32'h1);
    tick(40);
    chk(r_ncmd == 0, "R5", "enable rewrite no restart", r_ncmd, 0);

    // R6 stop mid-walk
    clr_counts();
    r_rdy = 0;
    wr_r(8'h14, 32'h0);
    wr_r(8'h14, 32'h1);
    tick(10);
    chk(r_cv, "R6", "command pending before stop", r_cv, 1);
    wr_r(8'h14, 32'h0);
    chk(!r_cv && !r_mreq, "R6", "quiet after stop", {r_cv, r_mreq}, 0);
    r_rdy = 1; tick(30);
    chk(r_ncmd == 0 && r_ndone == 0, "R6", "nothing after stop", r_ncmd + r_ndone, 0);

    // R11 stop and final acceptance in the same cycle
    clr_counts();
    r_rdy = 0;
    wr_r(8'h04, 32'd64);
    wr_r(8'h14, 32'h1);
    tick(10);
    r_rdy = 1; r_wr = 1; r_wa = 8'h14; r_wd = 32'h0;
    tick(1);
    r_wr = 0;
    tick(20);
    chk(r_ncmd == 1, "R11", "last command accepted", r_ncmd, 1);
    chk(r_ndone == 0, "R11", "no done on stop", r_ndone, 0);
    chk(!r_cv, "R11", "port idle", r_cv, 0);

    finish_run();
  end
endmodule